// File: doc/BRIEF.md
# External Interrupt Sense and Latch Unit

This block conditions a small group of asynchronous external interrupt pins (up to four) and turns each into a qualified request line. Every pin first crosses into the block clock through its own synchroniser. It is then interpreted under a per-pin 2-bit sense code that selects one of four modes: active-high level, active-low level, rising edge or falling edge. In the two edge modes a detected transition sets a sticky per-pin latch. The latch holds until software writes a one to that pin's clear bit.

All configuration lives in one 32-bit control word, reached through a plain write-enable/write-data port with a read-data output that is always valid. The control word holds the sense fields, the per-pin enables, a master enable that gates every pin, and a routing flag for the critical source. The routing flag is stored and driven out for a neighbouring block. The per-pin fields sit at positions that descend as the pin number rises. Those positions are part of the contract with software.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset the control word reads 0x00000000, every request line is 0, and the routing output is 0.
- R2: The sense field of pin n occupies control bits [23-2n:22-2n]. Code 0 is active-high level and code 3 is active-low level. In both level modes the request follows the pin with exactly two clock edges of synchroniser latency, and no latch is involved.
- R3: Code 1 is rising edge and code 2 is falling edge. A qualifying transition sets the pin's latch, and its request rises on the third clock edge after the pin changes. A transition of the opposite direction sets nothing. The latch stays set after the pin returns to its idle level.
- R4: Writing a 1 to control bit 27-n clears the latch of pin n in that write's clock edge. Writing a 0 there leaves the latch unchanged. Bits 27:24 always read back as 0.
- R5: Control bit 11-n enables the request of pin n (1 = enabled). A disabled pin drives no request, but its latch still captures edges, and that captured event appears when the pin is enabled again.
- R6: Control bit 12 is the master enable. While it is 0 every request line is 0, whatever the pins and latches hold.
- R7: Control bit 0 is stored, read back and driven on `crit_normal`. The sense, enable and master fields read back as written. All bits outside the defined fields read 0.
- R8: When an edge is detected in the same cycle as a clear write for that pin, the latch ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Raw asynchronous external interrupt pins |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data, always valid |
| irq_req | output | NPINS | Qualified request per pin |
| crit_normal | output | 1 | Stored critical-routing flag (control bit 0) |

## Verification
The bench goes after the latency of each mode: it samples one edge early and then on the edge itself. An extra or missing synchroniser stage would show as a request that comes one cycle off. It drives a rising transition into a falling-edge pin, and it writes zeros to the clear bits. A decoder that reacted to the wrong direction, or treated clear as plain storage, would leave a latch set or cleared in the wrong place. It lines a pin edge up exactly with a clear write, which catches a clear-over-set priority that drops a fresh event. It also checks that a latch caught while its pin was disabled still fires once the pin is enabled again, and that a cleared master enable silences every pin.

// File: rtl/exirq_pkg.sv
package exirq_pkg;

   localparam int CTL_W      = 32;
   localparam int MAX_PINS   = 4;
   localparam int MASTER_BIT = 12;
   localparam int CRIT_BIT   = 0;

   typedef enum logic [1:0] {
      SNS_LVL_HI = 2'd0,
      SNS_RISE   = 2'd1,
      SNS_FALL   = 2'd2,
      SNS_LVL_LO = 2'd3
   } sense_e;

   // Low bit of the 2-bit sense field of pin n.
   function automatic int sense_lo(input int n);
      return 22 - 2 * n;
   endfunction

   function automatic int en_pos(input int n);
      return 11 - n;
   endfunction

   function automatic int clr_pos(input int n);
      return 27 - n;
   endfunction

   function automatic logic is_edge(input sense_e s);
      return (s == SNS_RISE) || (s == SNS_FALL);
   endfunction

endpackage

// File: rtl/exirq_sync.sv
module exirq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("exirq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/exirq_ctl_reg.sv
module exirq_ctl_reg
   import exirq_pkg::*;
#(
   parameter int NPINS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [CTL_W-1:0]       wdata,
   output logic [CTL_W-1:0]       rdata,
   output logic [NPINS-1:0][1:0]  sense_o,
   output logic [NPINS-1:0]       en_o,
   output logic                   master_o,
   output logic                   crit_o,
   output logic [NPINS-1:0]       clr_o
);

   logic [NPINS-1:0][1:0] sense_q;
   logic [NPINS-1:0]      en_q;
   logic                  master_q;
   logic                  crit_q;

   // Bits outside the defined fields are not stored.
   logic unused_wbits;
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q  <= '0;
         en_q     <= '0;
         master_q <= 1'b0;
         crit_q   <= 1'b0;
      end else if (we) begin
         for (int n = 0; n < NPINS; n++) begin
            sense_q[n] <= wdata[sense_lo(n) +: 2];
            en_q[n]    <= wdata[en_pos(n)];
         end
         master_q <= wdata[MASTER_BIT];
         crit_q   <= wdata[CRIT_BIT];
      end
   end

   // Clear bits are a one-cycle pulse, never stored.
   always_comb begin
      for (int n = 0; n < NPINS; n++) begin
         clr_o[n] = we & wdata[clr_pos(n)];
      end
   end

   always_comb begin
      rdata = '0;
      for (int n = 0; n < NPINS; n++) begin
         rdata[sense_lo(n) +: 2] = sense_q[n];
         rdata[en_pos(n)]        = en_q[n];
      end
      rdata[MASTER_BIT] = master_q;
      rdata[CRIT_BIT]   = crit_q;
   end

   assign sense_o  = sense_q;
   assign en_o     = en_q;
   assign master_o = master_q;
   assign crit_o   = crit_q;

   // R7: a write lands in the read-back value on the next cycle
   a_r7_master_readback: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (rdata[MASTER_BIT] == $past(wdata[MASTER_BIT])));

endmodule

// File: rtl/exirq_pin.sv
module exirq_pin
   import exirq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_async,
   input  logic [1:0] sense,
   input  logic       clr,
   output logic       req_raw
);

   logic   lvl;
   logic   prev_q;
   logic   latch_q;
   logic   latch_d;
   logic   edge_hit;
   logic   edge_mode;
   sense_e mode;

   exirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_async),
      .q     (lvl)
   );

   assign mode      = sense_e'(sense);
   assign edge_mode = is_edge(mode);

   always_comb begin
      case (mode)
         SNS_RISE: edge_hit = lvl & ~prev_q;
         SNS_FALL: edge_hit = ~lvl & prev_q;
         default:  edge_hit = 1'b0;
      endcase
   end

   // A new edge wins over a clear written in the same cycle.
   always_comb begin
      if (!edge_mode)    latch_d = 1'b0;
      else if (edge_hit) latch_d = 1'b1;
      else if (clr)      latch_d = 1'b0;
      else               latch_d = latch_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         prev_q  <= lvl;
         latch_q <= latch_d;
      end
   end

   always_comb begin
      case (mode)
         SNS_LVL_HI: req_raw = lvl;
         SNS_LVL_LO: req_raw = ~lvl;
         default:    req_raw = latch_q;
      endcase
   end

   // R3: a set latch holds while no clear arrives
   a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && latch_q && !clr) |=> latch_q);

   // R8: edge together with clear leaves the latch set
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_hit && clr) |=> latch_q);

   // R4: a clear with no competing edge empties the latch
   a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && clr && !edge_hit) |=> !latch_q);

   // R2: level modes keep the latch empty
   a_r2_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_mode |=> !latch_q);

endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
   import exirq_pkg::*;
#(
   parameter int NPINS       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pin_in,
   input  logic              reg_we,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [NPINS-1:0]  irq_req,
   output logic              crit_normal
);

   if (NPINS < 1 || NPINS > MAX_PINS) begin : g_bad_npins
      $error("ext_irq_cond: NPINS must be between 1 and 4");
   end

   logic [NPINS-1:0][1:0] sense;
   logic [NPINS-1:0]      en;
   logic [NPINS-1:0]      clr;
   logic [NPINS-1:0]      raw;
   logic                  master;

   exirq_ctl_reg #(.NPINS(NPINS)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .sense_o  (sense),
      .en_o     (en),
      .master_o (master),
      .crit_o   (crit_normal),
      .clr_o    (clr)
   );

   for (genvar n = 0; n < NPINS; n++) begin : g_pin
      exirq_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_async (pin_in[n]),
         .sense     (sense[n]),
         .clr       (clr[n]),
         .req_raw   (raw[n])
      );

      assign irq_req[n] = raw[n] & en[n] & master;

      // R5: a disabled pin never requests
      a_r5_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
         !reg_rdata[en_pos(n)] |-> !irq_req[n]);
   end

   // R6: master enable off silences every line
   a_r6_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[MASTER_BIT] |-> (irq_req == '0));

endmodule

// File: tb/sim_ext_irq_cond.sv
`timescale 1ns/1ps
module sim_ext_irq_cond;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  pin_in = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  irq_req;
   logic        crit_normal;

   always #10 clk = ~clk;   // 50 MHz

   ext_irq_cond u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_in      (pin_in),
      .reg_we      (reg_we),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .irq_req     (irq_req),
      .crit_normal (crit_normal)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Bench model of the configuration fields.
   logic       m_master = 1'b0;
   logic [3:0] m_en     = '0;
   logic [1:0] m_sense [4] = '{2'd0, 2'd0, 2'd0, 2'd0};
   logic       m_crit   = 1'b0;

   // Scoreboard queues.
   logic [3:0]  q_irq  [$];
   logic [31:0] q_rd   [$];
   logic        q_crit [$];
   string       q_tag  [$];

   function automatic logic [31:0] word(input logic [3:0] clr);
      logic [31:0] w = '0;
      for (int n = 0; n < 4; n++) begin
         w[23-2*n -: 2] = m_sense[n];
         w[11-n]        = m_en[n];
         w[27-n]        = clr[n];
      end
      w[12] = m_master;
      w[0]  = m_crit;
      return w;
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Monitor: pops expected items and compares away from the active edge.
   always @(negedge clk) begin
      if (q_irq.size() > 0) begin
         automatic logic [3:0]  e_irq  = q_irq.pop_front();
         automatic logic [31:0] e_rd   = q_rd.pop_front();
         automatic logic        e_crit = q_crit.pop_front();
         automatic string       e_tag  = q_tag.pop_front();
         check(e_tag, "irq_req", {28'd0, irq_req}, {28'd0, e_irq});
         check(e_tag, "reg_rdata", reg_rdata, e_rd);
         check(e_tag, "crit_normal", {31'd0, crit_normal}, {31'd0, e_crit});
      end
   end

   // Driver helpers.
   task automatic expect_after(input int n, input logic [3:0] irq, input string tag);
      repeat (n) @(posedge clk);
      #1;
      q_irq.push_back(irq);
      q_rd.push_back(word(4'd0));
      q_crit.push_back(m_crit);
      q_tag.push_back(tag);
      @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [3:0] clr);
      @(negedge clk);
      #2;
      reg_we    = 1'b1;
      reg_wdata = word(clr) | 32'hE000_E0FE;   // undefined bits must be ignored
      @(posedge clk);
      #1;
      reg_we = 1'b0;
   endtask

   task automatic set_pins(input logic [3:0] v);
      @(negedge clk);
      #2;
      pin_in = v;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;
      expect_after(0, 4'b0000, "R1 reset state");

      // Master on, all enabled, level high everywhere, routing flag set.
      m_master = 1'b1; m_en = 4'hF; m_crit = 1'b1;
      wr(4'hF);
      expect_after(0, 4'b0000, "R7 R4 readback with clear bits reading 0");

      set_pins(4'b0001);
      expect_after(1, 4'b0000, "R2 level high one edge early");
      expect_after(1, 4'b0001, "R2 level high after two edges");
      set_pins(4'b0000);
      expect_after(2, 4'b0000, "R2 level high release");

      m_sense[1] = 2'd3;
      wr(4'h0);
      expect_after(0, 4'b0010, "R2 level low with pin low");
      set_pins(4'b0010);
      expect_after(2, 4'b0000, "R2 level low with pin high");

      m_sense[2] = 2'd1;
      wr(4'h0);
      set_pins(4'b0110);
      expect_after(2, 4'b0000, "R3 rising edge not yet latched");
      expect_after(1, 4'b0100, "R3 rising edge latched on third edge");
      set_pins(4'b0010);
      expect_after(3, 4'b0100, "R3 latch sticky after pin release");

      wr(4'b0100);
      expect_after(0, 4'b0000, "R4 write one clears latch");

      m_sense[3] = 2'd2;
      wr(4'h0);
      set_pins(4'b1010);
      expect_after(3, 4'b0000, "R3 falling mode ignores rising edge");
      set_pins(4'b0010);
      expect_after(3, 4'b1000, "R3 falling edge latched");
      wr(4'h0);
      expect_after(0, 4'b1000, "R4 writing zero leaves latch");
      wr(4'b1000);
      expect_after(0, 4'b0000, "R4 clear falling latch");

      m_master = 1'b0;
      wr(4'h0);
      set_pins(4'b0011);
      expect_after(2, 4'b0000, "R6 master off blocks level request");
      m_master = 1'b1;
      wr(4'h0);
      expect_after(0, 4'b0001, "R6 master on releases request");
      set_pins(4'b0010);
      expect_after(2, 4'b0000, "R2 pin0 released");

      m_en = 4'b1011;
      wr(4'h0);
      set_pins(4'b0110);
      expect_after(3, 4'b0000, "R5 disabled pin drives no request");
      m_en = 4'hF;
      wr(4'h0);
      expect_after(0, 4'b0100, "R5 latch captured while disabled");
      set_pins(4'b0010);
      wr(4'b0100);
      expect_after(0, 4'b0000, "R4 clear after enable test");

      // Edge detected in the same cycle as a clear write.
      set_pins(4'b0110);
      @(negedge clk);
      wr(4'b0100);
      expect_after(0, 4'b0100, "R8 set wins over simultaneous clear");
      wr(4'b0100);
      expect_after(0, 4'b0000, "R8 later clear empties latch");

      m_crit = 1'b0;
      wr(4'h0);
      expect_after(0, 4'b0000, "R7 routing flag cleared");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule